// File: doc/BRIEF.md
# Multicycle Processor Control State Machine

This block sequences a multicycle 32-bit load/store processor built around one shared memory and one ALU. Every instruction spends several clock cycles in the datapath, and in each cycle this block drives the selects and write enables for that step. It reads two inputs: the 6-bit opcode held in the instruction register and the ALU zero flag. The datapath registers, the ALU and the memory belong to the surrounding design.

The machine has thirteen states. `S_FETCH` reads the instruction and advances the PC by 4, then always moves to `S_DECODE`. `S_DECODE` reads the registers and precomputes a branch target. It then dispatches on the opcode:

- R-type goes to `S_RT_EXEC` and then `S_RT_WB`.
- Loads and stores share `S_ADDR`. A store continues to `S_ST_MEM`. A load continues to `S_LD_MEM` and then `S_LD_WB`.
- A branch-if-equal goes to `S_BR_DONE`.
- The scaled-index load computes rd = Mem[rt + 4*rs]. It walks `S_SC_MUL`, `S_SC_ADD`, `S_SC_MEM` and `S_SC_WB`. Its second ALU step feeds the ALU output register back into the ALU through a three-way A-side select.
- An unrecognised opcode returns straight to `S_FETCH`.

Every final state (`S_RT_WB`, `S_ST_MEM`, `S_LD_WB`, `S_BR_DONE`, `S_SC_WB`) returns to `S_FETCH`.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset puts the machine in the fetch state on the next rising edge. A reset raised mid-instruction takes effect only at that edge.
- R2: Fetch drives mem_rd=1, ir_wr=1, pc_wr=1, iord=0, alu_src_a=0 (PC), alu_src_b=1 (constant 4), alu_op=3'b010 (add) and pc_src=0. The state after fetch is always decode.
- R3: Decode drives alu_src_a=0, alu_src_b=3 (shifted sign-extended offset) and alu_op=3'b010. Its successor is chosen by opcode: 000000 R-type, 100011 load, 101011 store, 000100 branch, 110011 scaled load. Any other opcode returns to fetch.
- R4: R-type takes two cycles. The first drives alu_src_a=1 (register A), alu_src_b=0 (register B) and alu_op=3'b001 (operation taken from the function field). The second drives reg_dst=1, mem_to_reg=0 and reg_wr=1. Fetch follows.
- R5: Load and store share one address cycle driving alu_src_a=1, alu_src_b=2 (sign-extended immediate) and alu_op=3'b010.
- R6: A store then drives iord=1 and mem_wr=1 for one cycle and returns to fetch.
- R7: A load then drives iord=1 and mem_rd=1. It then writes back with reg_dst=0, mem_to_reg=1 and reg_wr=1, and returns to fetch.
- R8: Branch completion drives alu_src_a=1, alu_src_b=0, alu_op=3'b110 (subtract), pc_src=1 and pc_wr_cond=1. The PC load enable pc_en follows alu_zero in that cycle. Fetch follows.
- R9: The scaled load runs four steps in order:
  - multiply with alu_src_a=1, alu_src_b=1 and alu_op=3'b100;
  - add with alu_src_a=2 (ALU output register), alu_src_b=0 and alu_op=3'b010;
  - read with iord=1 and mem_rd=1;
  - write back with reg_dst=1, mem_to_reg=1 and reg_wr=1.

  Fetch follows.
- R10: pc_en equals pc_wr OR (pc_wr_cond AND alu_zero). In every state other than branch completion, alu_zero has no effect on any output.
- R11: Every select and enable not named for a state is 0 in that state.
- R12: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| iord | output | 1 | Memory address select: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when ALU zero |
| pc_en | output | 1 | Combined PC load enable |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| alu_src_a | output | 2 | ALU A select: 0 PC, 1 register A, 2 ALU output register |
| alu_src_b | output | 2 | ALU B select: 0 register B, 1 constant 4, 2 sign-extended, 3 shifted |
| alu_op | output | 3 | ALU operation code |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write-back data: 0 ALU output register, 1 memory data register |
| reg_wr | output | 1 | Register file write enable |

## Verification
The assertions check several ordering rules on every cycle:
- reset lands in fetch, and fetch always leads to decode;
- branch completion always returns to fetch;
- the scaled load's multiply, add and read steps occur strictly in sequence;
- memory read and write never overlap, and the two PC write enables never overlap;
- every register or memory write-back is followed by a fetch.

The exact signal values of each state, the opcode dispatch across all 64 opcodes, the zero-flag gating of the branch, and the insensitivity to alu_zero elsewhere can only be shown by the bench. It sweeps every opcode with both values of the zero flag and compares the full output vector cycle by cycle.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OP_W  = 6;
    localparam int ASA_W = 2;
    localparam int ASB_W = 2;
    localparam int AOP_W = 3;

    typedef enum logic [3:0] {
        S_FETCH,
        S_DECODE,
        S_BR_DONE,
        S_RT_EXEC,
        S_RT_WB,
        S_ADDR,
        S_ST_MEM,
        S_LD_MEM,
        S_LD_WB,
        S_SC_MUL,
        S_SC_ADD,
        S_SC_MEM,
        S_SC_WB
    } state_t;

    typedef enum logic [2:0] {
        CL_RTYPE,
        CL_LOAD,
        CL_STORE,
        CL_BRANCH,
        CL_SCALED,
        CL_OTHER
    } op_class_t;

    // ALU operation codes
    localparam logic [AOP_W-1:0] AOP_NONE  = 3'b000;
    localparam logic [AOP_W-1:0] AOP_FUNCT = 3'b001;
    localparam logic [AOP_W-1:0] AOP_ADD   = 3'b010;
    localparam logic [AOP_W-1:0] AOP_MUL   = 3'b100;
    localparam logic [AOP_W-1:0] AOP_SUB   = 3'b110;

    // ALU A-side selects
    localparam logic [ASA_W-1:0] ASA_PC     = 2'd0;
    localparam logic [ASA_W-1:0] ASA_REGA   = 2'd1;
    localparam logic [ASA_W-1:0] ASA_ALUOUT = 2'd2;

    // ALU B-side selects
    localparam logic [ASB_W-1:0] ASB_REGB  = 2'd0;
    localparam logic [ASB_W-1:0] ASB_FOUR  = 2'd1;
    localparam logic [ASB_W-1:0] ASB_SEXT  = 2'd2;
    localparam logic [ASB_W-1:0] ASB_SHIFT = 2'd3;

    typedef struct packed {
        logic             iord;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_wr;
        logic             pc_wr;
        logic             pc_wr_cond;
        logic             pc_src;
        logic [ASA_W-1:0] src_a;
        logic [ASB_W-1:0] src_b;
        logic [AOP_W-1:0] aop;
        logic             reg_dst;
        logic             mem_to_reg;
        logic             reg_wr;
    } ctrl_t;

endpackage

// File: rtl/mc_op_class.sv
module mc_op_class
    import mc_ctrl_pkg::*;
#(
    parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
    parameter logic [OP_W-1:0] OP_SCALED = 6'b110011
) (
    input  logic [OP_W-1:0] opcode,
    output op_class_t       op_class
);

    localparam int N_KNOWN = 5;

    logic [N_KNOWN-1:0][OP_W-1:0] known_op;
    op_class_t [N_KNOWN-1:0]      known_cl;
    logic [N_KNOWN-1:0]           hit;

    assign known_op = {OP_SCALED, OP_BRANCH, OP_STORE, OP_LOAD, OP_RTYPE};
    assign known_cl = {CL_SCALED, CL_BRANCH, CL_STORE, CL_LOAD, CL_RTYPE};

    for (genvar gi = 0; gi < N_KNOWN; gi++) begin : g_match
        assign hit[gi] = (opcode == known_op[gi]);
    end

    // Lowest matching entry wins; no match means an unknown opcode.
    always_comb begin
        op_class = CL_OTHER;
        for (int i = N_KNOWN - 1; i >= 0; i--) begin
            if (hit[i]) op_class = known_cl[i];
        end
    end

endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
    import mc_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  op_class_t op_class,
    output state_t    state
);

    state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_FETCH;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = S_FETCH;
        unique case (state_q)
            S_FETCH:  state_d = S_DECODE;
            S_DECODE: begin
                unique case (op_class)
                    CL_RTYPE:              state_d = S_RT_EXEC;
                    CL_LOAD, CL_STORE:     state_d = S_ADDR;
                    CL_BRANCH:             state_d = S_BR_DONE;
                    CL_SCALED:             state_d = S_SC_MUL;
                    default:               state_d = S_FETCH;
                endcase
            end
            S_RT_EXEC: state_d = S_RT_WB;
            S_ADDR:    state_d = (op_class == CL_STORE) ? S_ST_MEM : S_LD_MEM;
            S_LD_MEM:  state_d = S_LD_WB;
            S_SC_MUL:  state_d = S_SC_ADD;
            S_SC_ADD:  state_d = S_SC_MEM;
            S_SC_MEM:  state_d = S_SC_WB;
            S_RT_WB, S_ST_MEM, S_LD_WB, S_BR_DONE, S_SC_WB: state_d = S_FETCH;
            default:   state_d = S_FETCH;
        endcase
    end

    assign state = state_q;

    assert_reset_to_fetch_R1: assert property (@(posedge clk)
        $past(rst) |-> (state_q == S_FETCH));

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FETCH) |=> (state_q == S_DECODE));

    assert_branch_returns_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_BR_DONE) |=> (state_q == S_FETCH));

    assert_scaled_mul_add_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SC_MUL) |=> (state_q == S_SC_ADD));

    assert_scaled_add_read_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SC_ADD) |=> (state_q == S_SC_MEM));

endmodule

// File: rtl/mc_ctrl_dec.sv
module mc_ctrl_dec
    import mc_ctrl_pkg::*;
(
    input  state_t state,
    output ctrl_t  ctl
);

    always_comb begin
        ctl = '0;
        unique case (state)
            S_FETCH: begin
                ctl.mem_rd = 1'b1;
                ctl.ir_wr  = 1'b1;
                ctl.pc_wr  = 1'b1;
                ctl.src_a  = ASA_PC;
                ctl.src_b  = ASB_FOUR;
                ctl.aop    = AOP_ADD;
            end
            S_DECODE: begin
                ctl.src_a = ASA_PC;
                ctl.src_b = ASB_SHIFT;
                ctl.aop   = AOP_ADD;
            end
            S_BR_DONE: begin
                ctl.src_a      = ASA_REGA;
                ctl.src_b      = ASB_REGB;
                ctl.aop        = AOP_SUB;
                ctl.pc_src     = 1'b1;
                ctl.pc_wr_cond = 1'b1;
            end
            S_RT_EXEC: begin
                ctl.src_a = ASA_REGA;
                ctl.src_b = ASB_REGB;
                ctl.aop   = AOP_FUNCT;
            end
            S_RT_WB: begin
                ctl.reg_dst = 1'b1;
                ctl.reg_wr  = 1'b1;
            end
            S_ADDR: begin
                ctl.src_a = ASA_REGA;
                ctl.src_b = ASB_SEXT;
                ctl.aop   = AOP_ADD;
            end
            S_ST_MEM: begin
                ctl.iord   = 1'b1;
                ctl.mem_wr = 1'b1;
            end
            S_LD_MEM, S_SC_MEM: begin
                ctl.iord   = 1'b1;
                ctl.mem_rd = 1'b1;
            end
            S_LD_WB: begin
                ctl.mem_to_reg = 1'b1;
                ctl.reg_wr     = 1'b1;
            end
            S_SC_MUL: begin
                ctl.src_a = ASA_REGA;
                ctl.src_b = ASB_FOUR;
                ctl.aop   = AOP_MUL;
            end
            S_SC_ADD: begin
                ctl.src_a = ASA_ALUOUT;
                ctl.src_b = ASB_REGB;
                ctl.aop   = AOP_ADD;
            end
            S_SC_WB: begin
                ctl.reg_dst    = 1'b1;
                ctl.mem_to_reg = 1'b1;
                ctl.reg_wr     = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter logic [OP_W-1:0] OP_RTYPE  = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
    parameter logic [OP_W-1:0] OP_SCALED = 6'b110011
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  opcode,
    input  logic             alu_zero,
    output logic             iord,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             pc_en,
    output logic             pc_src,
    output logic [ASA_W-1:0] alu_src_a,
    output logic [ASB_W-1:0] alu_src_b,
    output logic [AOP_W-1:0] alu_op,
    output logic             reg_dst,
    output logic             mem_to_reg,
    output logic             reg_wr
);

    op_class_t op_class;
    state_t    state;
    ctrl_t     ctl;

    mc_op_class #(
        .OP_RTYPE (OP_RTYPE),
        .OP_LOAD  (OP_LOAD),
        .OP_STORE (OP_STORE),
        .OP_BRANCH(OP_BRANCH),
        .OP_SCALED(OP_SCALED)
    ) u_class (
        .opcode  (opcode),
        .op_class(op_class)
    );

    mc_ctrl_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .op_class(op_class),
        .state   (state)
    );

    mc_ctrl_dec u_dec (
        .state(state),
        .ctl  (ctl)
    );

    assign iord       = ctl.iord;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign ir_wr      = ctl.ir_wr;
    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign pc_src     = ctl.pc_src;
    assign alu_src_a  = ctl.src_a;
    assign alu_src_b  = ctl.src_b;
    assign alu_op     = ctl.aop;
    assign reg_dst    = ctl.reg_dst;
    assign mem_to_reg = ctl.mem_to_reg;
    assign reg_wr     = ctl.reg_wr;

    // Combined PC load: unconditional write, or conditional write on zero.
    assign pc_en = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);

    assert_mem_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_pc_write_kinds_R11: assert property (@(posedge clk) disable iff (rst)
        !(pc_wr && pc_wr_cond));

    assert_writeback_then_fetch_R4: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ir_wr);

    assert_store_then_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_wr);

endmodule

// File: tb/mc_ctrl_fsm_bench.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_bench;

    localparam int P_FETCH = 0,  P_DECODE = 1, P_BR = 2,    P_RX = 3,  P_RWB = 4;
    localparam int P_ADDR  = 5,  P_STM    = 6, P_LDM = 7,   P_LWB = 8;
    localparam int P_SMUL  = 9,  P_SADD   = 10, P_SMEM = 11, P_SWB = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b100011;
    logic       alu_zero = 1'b1;
    logic       iord, mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, pc_en, pc_src;
    logic [1:0] alu_src_a, alu_src_b;
    logic [2:0] alu_op;
    logic       reg_dst, mem_to_reg, reg_wr;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;

    always #4 clk = ~clk;

    mc_ctrl_fsm u_mc_ctrl_fsm (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_en(pc_en), .pc_src(pc_src),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
        .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr)
    );

    wire [17:0] got = {iord, mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, pc_en, pc_src,
                       alu_src_a, alu_src_b, alu_op, reg_dst, mem_to_reg, reg_wr};

    function automatic logic [17:0] mk(
        input logic io, mr, mw, irw, pw, pwc, pen, psrc,
        input logic [1:0] sa, sb, input logic [2:0] op,
        input logic rd, m2r, rw);
        return {io, mr, mw, irw, pw, pwc, pen, psrc, sa, sb, op, rd, m2r, rw};
    endfunction

    // Expected output vector per phase (R2..R11); unnamed fields are zero (R11).
    function automatic logic [17:0] expect_vec(input int ph, input logic z);
        case (ph)
            P_FETCH:  return mk(0,1,0,1,1,0,1,0, 2'd0,2'd1,3'b010, 0,0,0);
            P_DECODE: return mk(0,0,0,0,0,0,0,0, 2'd0,2'd3,3'b010, 0,0,0);
            P_BR:     return mk(0,0,0,0,0,1,z,1, 2'd1,2'd0,3'b110, 0,0,0);
            P_RX:     return mk(0,0,0,0,0,0,0,0, 2'd1,2'd0,3'b001, 0,0,0);
            P_RWB:    return mk(0,0,0,0,0,0,0,0, 2'd0,2'd0,3'b000, 1,0,1);
            P_ADDR:   return mk(0,0,0,0,0,0,0,0, 2'd1,2'd2,3'b010, 0,0,0);
            P_STM:    return mk(1,0,1,0,0,0,0,0, 2'd0,2'd0,3'b000, 0,0,0);
            P_LDM:    return mk(1,1,0,0,0,0,0,0, 2'd0,2'd0,3'b000, 0,0,0);
            P_LWB:    return mk(0,0,0,0,0,0,0,0, 2'd0,2'd0,3'b000, 0,1,1);
            P_SMUL:   return mk(0,0,0,0,0,0,0,0, 2'd1,2'd1,3'b100, 0,0,0);
            P_SADD:   return mk(0,0,0,0,0,0,0,0, 2'd2,2'd0,3'b010, 0,0,0);
            P_SMEM:   return mk(1,1,0,0,0,0,0,0, 2'd0,2'd0,3'b000, 0,0,0);
            default:  return mk(0,0,0,0,0,0,0,0, 2'd0,2'd0,3'b000, 1,1,1);
        endcase
    endfunction

    function automatic string req_of(input int ph);
        case (ph)
            P_FETCH:          return "R2";
            P_DECODE:         return "R3";
            P_BR:             return "R8";
            P_RX, P_RWB:      return "R4";
            P_ADDR:           return "R5";
            P_STM:            return "R6";
            P_LDM, P_LWB:     return "R7";
            default:          return "R9";
        endcase
    endfunction

    // Opcode class: 0 R-type, 1 load, 2 store, 3 branch, 4 scaled, 5 unknown (R3)
    function automatic int cls(input logic [5:0] op);
        if (op == 6'b000000) return 0;
        if (op == 6'b100011) return 1;
        if (op == 6'b101011) return 2;
        if (op == 6'b000100) return 3;
        if (op == 6'b110011) return 4;
        return 5;
    endfunction

    // Phase at step i of an instruction of class c, -1 past the end.
    function automatic int phase_at(input int c, input int i);
        if (i == 0) return P_FETCH;
        if (i == 1) return P_DECODE;
        case (c)
            0: case (i) 2: return P_RX;   3: return P_RWB; default: return -1; endcase
            1: case (i) 2: return P_ADDR; 3: return P_LDM; 4: return P_LWB; default: return -1; endcase
            2: case (i) 2: return P_ADDR; 3: return P_STM; default: return -1; endcase
            3: case (i) 2: return P_BR;   default: return -1; endcase
            4: case (i) 2: return P_SMUL; 3: return P_SADD; 4: return P_SMEM;
                        5: return P_SWB;  default: return -1; endcase
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [17:0] exp_v);
        tests++;
        if (got !== exp_v) begin
            fails++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, got, exp_v);
        end
    endtask

    // Entered at a falling edge with the machine in fetch; leaves the same way.
    task automatic run_instr(input logic [5:0] op, input logic z);
        int c;
        c = cls(op);
        for (int i = 0; phase_at(c, i) >= 0; i++) begin
            opcode   = op;
            alu_zero = z;
            #1;
            chk(req_of(phase_at(c, i)), expect_vec(phase_at(c, i), z));
            @(negedge clk);
        end
    endtask

    initial begin
        // R1: reset state
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            #1 chk("R1", expect_vec(P_FETCH, 1'b1));
        end
        @(negedge clk);
        rst = 1'b0;

        // Sweep every opcode with both zero-flag values (R2..R12; R10 zero insensitivity)
        for (int o = 0; o < 64; o++) begin
            for (int z = 0; z < 2; z++) begin
                run_instr(6'(o), z[0]);
            end
        end

        // R1: reset raised inside a scaled load is synchronous
        opcode = 6'b110011;
        alu_zero = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1 chk(req_of(phase_at(4, i)), expect_vec(phase_at(4, i), 1'b0));
            @(negedge clk);
        end
        rst = 1'b1;
        #1 chk("R1 sync (no early reset)", expect_vec(P_SADD, 1'b0));
        @(negedge clk);
        #1 chk("R1 reset mid-instruction", expect_vec(P_FETCH, 1'b0));
        rst = 1'b0;
        @(negedge clk);
        #1 chk("R2 decode after reset", expect_vec(P_DECODE, 1'b0));
        @(negedge clk);

        // Back to back: branch taken, then store, then a final fetch
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_instr(6'b000100, 1'b1);
        run_instr(6'b101011, 1'b0);
        opcode = 6'b000000;
        #1 chk("R8 return to fetch", expect_vec(P_FETCH, 1'b0));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule